// File: doc/BRIEF.md
# Single-Operand ALU with Condition Codes

This unit carries out the one-operand data operations of a 16-bit minicomputer datapath: clearing, one's and two's complement, increment and decrement, adding or subtracting the carry flag, rotates through carry, arithmetic shifts, testing and sign extension. Each operation runs on either a full word or the low byte. The surrounding datapath fetches the operand and supplies the current N and C flags. It presents a 4-bit operation code together with a byte/word select. The unit returns the result, a flag that says whether the result is to be written back, the new N, Z, V and C values, and one update mask bit per flag. The status register uses the mask to decide which of its bits to load.

The operation code is the instruction's bits 11:6 with octal 50 subtracted. Codes 12 to 14 select operations that this unit does not execute. All outputs are registered and appear one clock after a cycle in which `in_valid` is high, together with `out_valid`.

Top module: `sop_alu_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle that follows a cycle with `in_valid` high, and all result and flag outputs are updated in that same cycle.
- R2: With `byte_mode`=1 the sign is bit 7, the operand and result are limited to 8 bits, and result bits 15:8 read 0. With `byte_mode`=0 the sign is bit 15 and the full 16 bits are used.
- R3: Code 0 (clear) gives result 0 with N=0, Z=1, V=0, C=0. Code 1 (complement) inverts every operand bit and gives V=0, C=1.
- R4: Code 2 (increment) and code 3 (decrement) add or subtract one and leave C unchanged (C update mask clear, `c_out`=`c_in`). Increment sets V when the result is the most negative value. Decrement sets V when the operand was the most negative value.
- R5: Code 4 (negate) gives the two's complement, sets V only when the result is the most negative value, and sets C whenever the result is nonzero.
- R6: Code 5 adds `c_in` and code 6 subtracts `c_in`. When `c_in`=1, add-carry sets C when the result wraps to 0 and sets V when the sign changes from positive to negative. Subtract-carry sets C when the result is all ones and sets V when the sign changes from negative to positive. When `c_in`=0, both pass the operand through with V=0 and C=0.
- R7: Code 8 rotates right, putting `c_in` into the sign bit. Code 9 rotates left, putting `c_in` into bit 0. In both cases the bit shifted out becomes C.
- R8: Code 10 shifts right and keeps the sign bit. Code 11 shifts left and fills bit 0 with 0. In both cases the bit shifted out becomes C.
- R9: For codes 8 to 11, the new V equals the new N xor the new C.
- R10: Code 7 (test) leaves `wr_en` low, gives result = the limited operand, and V=0, C=0.
- R11: Code 15 (sign extend) gives all ones (limited to the size) when `n_in`=1 and 0 otherwise, sets Z = not `n_in`, and clears the N, V and C update masks so that `n_out`=`n_in` and `c_out`=`c_in`.
- R12: For every executed code other than 15, N is the sign bit of the limited result and Z is set when that result is 0. Every update mask is set unless R4 or R11 clears it. A flag whose mask is clear reads `n_in` for N, `c_in` for C, and 0 for Z and V.
- R13: Codes 12, 13 and 14 give `wr_en`=0, result 0 and all four update masks clear.
- R14: While `rst_n` is low, every output reads 0 from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 4 | Operation code 0..15 |
| byte_mode | input | 1 | 1 = byte operation, 0 = word |
| operand | input | 16 | Operand value |
| n_in | input | 1 | Current N flag |
| c_in | input | 1 | Current C flag |
| out_valid | output | 1 | Registered outputs are new |
| result | output | 16 | Operation result |
| wr_en | output | 1 | Result is to be written back |
| n_out | output | 1 | New N flag |
| z_out | output | 1 | New Z flag |
| v_out | output | 1 | New V flag |
| c_out | output | 1 | New C flag |
| n_upd | output | 1 | Load N into status |
| z_upd | output | 1 | Load Z into status |
| v_upd | output | 1 | Load V into status |
| c_upd | output | 1 | Load C into status |

## Verification
Some properties hold in every cycle and are checked by assertions: the one-cycle valid timing, the zero upper byte in byte mode, Z agreeing with a zero result whenever Z is loaded, V equal to N xor C after any shift or rotate, no write-back from test or the unexecuted codes, and carry kept by increment and decrement. The exact value of each operation needs a reference model, so the bench's scenarios are what show it. These include the carry paths of add-carry and subtract-carry, the boundary operands 0, the most negative value and all ones in both sizes, and the flags that sign extension leaves alone.

// File: rtl/sop_alu_pkg.sv
// Package: shared operation codes and control bundle for the single-operand ALU.
// Assumes the 4-bit code is already reduced from the instruction word.
package sop_alu_pkg;

    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_CLR  = 4'd0,
        OP_COM  = 4'd1,
        OP_INC  = 4'd2,
        OP_DEC  = 4'd3,
        OP_NEG  = 4'd4,
        OP_ADC  = 4'd5,
        OP_SBC  = 4'd6,
        OP_TST  = 4'd7,
        OP_ROR  = 4'd8,
        OP_ROL  = 4'd9,
        OP_ASR  = 4'd10,
        OP_ASL  = 4'd11,
        OP_RSV0 = 4'd12,
        OP_RSV1 = 4'd13,
        OP_RSV2 = 4'd14,
        OP_SXT  = 4'd15
    } sop_op_e;

    // Per-unit control outputs: write-back, V/C values and their masks.
    typedef struct packed {
        logic hit;
        logic wr;
        logic v;
        logic c;
        logic v_upd;
        logic c_upd;
    } sop_ctl_t;

endpackage

// File: rtl/sop_alu_arith.sv
// Arithmetic/logic lane: clear, complement, inc/dec, negate, carry add/sub,
// test and sign extend. Pure combinational. Assumes BW < W.
module sop_alu_arith
    import sop_alu_pkg::*;
#(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  sop_op_e        op,
    input  logic           byte_mode,
    input  logic [W-1:0]   operand,
    input  logic           n_in,
    input  logic           c_in,
    output logic [W-1:0]   res,
    output sop_ctl_t       ctl
);
    localparam logic [W-1:0] FULL_MASK = '1;
    localparam logic [W-1:0] BYTE_MASK = {{(W-BW){1'b0}}, {BW{1'b1}}};
    localparam logic [W-1:0] W_SIGN    = W'(1) << (W-1);
    localparam logic [W-1:0] B_SIGN    = W'(1) << (BW-1);

    logic [W-1:0] msk, sgn, val, inc_v, dec_v;
    logic         val_neg;

    // Size-dependent mask, sign position and pre-computed +1/-1 values.
    always_comb begin
        msk     = byte_mode ? BYTE_MASK : FULL_MASK;
        sgn     = byte_mode ? B_SIGN : W_SIGN;
        val     = operand & msk;
        val_neg = |(val & sgn);
        inc_v   = (val + W'(1)) & msk;
        dec_v   = (val - W'(1)) & msk;
    end

    // Operation decode for this lane.
    always_comb begin
        res = '0;
        ctl = '{hit: 1'b1, wr: 1'b1, v: 1'b0, c: 1'b0, v_upd: 1'b1, c_upd: 1'b1};
        unique case (op)
            OP_CLR: begin
                res = '0;
            end
            OP_COM: begin
                res   = ~val & msk;
                ctl.c = 1'b1;
            end
            OP_INC: begin
                res       = inc_v;
                ctl.v     = (inc_v == sgn);
                ctl.c_upd = 1'b0;
            end
            OP_DEC: begin
                res       = dec_v;
                ctl.v     = (val == sgn);
                ctl.c_upd = 1'b0;
            end
            OP_NEG: begin
                res   = (~val + W'(1)) & msk;
                ctl.v = (((~val + W'(1)) & msk) == sgn);
                ctl.c = (val != '0);
            end
            OP_ADC: begin
                if (c_in) begin
                    res   = inc_v;
                    ctl.v = |(inc_v & sgn) & ~val_neg;
                    ctl.c = (inc_v == '0);
                end else begin
                    res = val;
                end
            end
            OP_SBC: begin
                if (c_in) begin
                    res   = dec_v;
                    ctl.v = val_neg & ~|(dec_v & sgn);
                    ctl.c = (dec_v == msk);
                end else begin
                    res = val;
                end
            end
            OP_TST: begin
                res    = val;
                ctl.wr = 1'b0;
            end
            OP_SXT: begin
                res       = n_in ? msk : '0;
                ctl.v_upd = 1'b0;
                ctl.c_upd = 1'b0;
            end
            default: begin
                ctl = '0;
            end
        endcase
    end
endmodule

// File: rtl/sop_alu_shift.sv
// Shift/rotate lane: rotate right/left through carry, arithmetic right/left.
// Pure combinational; V follows N xor C of the new flags.
module sop_alu_shift
    import sop_alu_pkg::*;
#(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  sop_op_e        op,
    input  logic           byte_mode,
    input  logic [W-1:0]   operand,
    input  logic           c_in,
    output logic [W-1:0]   res,
    output sop_ctl_t       ctl
);
    localparam logic [W-1:0] FULL_MASK = '1;
    localparam logic [W-1:0] BYTE_MASK = {{(W-BW){1'b0}}, {BW{1'b1}}};
    localparam logic [W-1:0] W_SIGN    = W'(1) << (W-1);
    localparam logic [W-1:0] B_SIGN    = W'(1) << (BW-1);

    logic [W-1:0] msk, sgn, val;
    logic         out_bit;

    // Size-dependent mask and sign position.
    always_comb begin
        msk = byte_mode ? BYTE_MASK : FULL_MASK;
        sgn = byte_mode ? B_SIGN : W_SIGN;
        val = operand & msk;
    end

    // Shift decode, carry-out capture and V rule.
    always_comb begin
        res     = '0;
        out_bit = 1'b0;
        ctl     = '{hit: 1'b1, wr: 1'b1, v: 1'b0, c: 1'b0, v_upd: 1'b1, c_upd: 1'b1};
        unique case (op)
            OP_ROR: begin
                out_bit = val[0];
                res     = (val >> 1) | (c_in ? sgn : '0);
            end
            OP_ROL: begin
                out_bit = |(val & sgn);
                res     = ((val << 1) | W'(c_in)) & msk;
            end
            OP_ASR: begin
                out_bit = val[0];
                res     = (val >> 1) | (val & sgn);
            end
            OP_ASL: begin
                out_bit = |(val & sgn);
                res     = (val << 1) & msk;
            end
            default: begin
                ctl = '0;
            end
        endcase
        if (ctl.hit) begin
            ctl.c = out_bit;
            ctl.v = |(res & sgn) ^ out_bit;
        end
    end
endmodule

// File: rtl/sop_alu_flags.sv
// Flag stage: chooses the active lane, derives N and Z from the limited
// result, and forms the four update masks. Combinational.
module sop_alu_flags
    import sop_alu_pkg::*;
#(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  sop_op_e        op,
    input  logic           byte_mode,
    input  logic           n_in,
    input  logic           c_in,
    input  logic [W-1:0]   ar_res,
    input  sop_ctl_t       ar_ctl,
    input  logic [W-1:0]   sh_res,
    input  sop_ctl_t       sh_ctl,
    output logic [W-1:0]   res,
    output logic           wr,
    output logic [3:0]     nzvc,
    output logic [3:0]     upd
);
    sop_ctl_t     sel;
    logic         sign_bit;
    logic         is_sxt;

    // Lane select: the shift lane claims its codes, else the arith lane.
    always_comb begin
        sel = sh_ctl.hit ? sh_ctl : ar_ctl;
        res = sh_ctl.hit ? sh_res : ar_res;
        wr  = sel.hit & sel.wr;
    end

    // Flag values and masks ordered {N, Z, V, C}.
    always_comb begin
        is_sxt   = (op == OP_SXT);
        sign_bit = byte_mode ? res[BW-1] : res[W-1];
        upd[3]   = sel.hit & ~is_sxt;
        upd[2]   = sel.hit;
        upd[1]   = sel.hit & sel.v_upd;
        upd[0]   = sel.hit & sel.c_upd;
        nzvc[3]  = upd[3] ? sign_bit : n_in;
        nzvc[2]  = upd[2] ? (is_sxt ? ~n_in : (res == '0)) : 1'b0;
        nzvc[1]  = upd[1] ? sel.v : 1'b0;
        nzvc[0]  = upd[0] ? sel.c : c_in;
    end
endmodule

// File: rtl/sop_alu_unit.sv
// Top: single-operand ALU with condition codes. Registers every output one
// cycle after in_valid. Assumes operand upper byte is ignored in byte mode.
module sop_alu_unit
    import sop_alu_pkg::*;
#(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [3:0]     op_sel,
    input  logic           byte_mode,
    input  logic [W-1:0]   operand,
    input  logic           n_in,
    input  logic           c_in,
    output logic           out_valid,
    output logic [W-1:0]   result,
    output logic           wr_en,
    output logic           n_out,
    output logic           z_out,
    output logic           v_out,
    output logic           c_out,
    output logic           n_upd,
    output logic           z_upd,
    output logic           v_upd,
    output logic           c_upd
);
    sop_op_e      op;
    logic [W-1:0] ar_res, sh_res, nx_res;
    sop_ctl_t     ar_ctl, sh_ctl;
    logic         nx_wr;
    logic [3:0]   nx_nzvc, nx_upd;

    assign op = sop_op_e'(op_sel);

    sop_alu_arith #(.W(W), .BW(BW)) u_arith (
        .op(op), .byte_mode(byte_mode), .operand(operand),
        .n_in(n_in), .c_in(c_in), .res(ar_res), .ctl(ar_ctl)
    );

    sop_alu_shift #(.W(W), .BW(BW)) u_shift (
        .op(op), .byte_mode(byte_mode), .operand(operand),
        .c_in(c_in), .res(sh_res), .ctl(sh_ctl)
    );

    sop_alu_flags #(.W(W), .BW(BW)) u_flags (
        .op(op), .byte_mode(byte_mode), .n_in(n_in), .c_in(c_in),
        .ar_res(ar_res), .ar_ctl(ar_ctl), .sh_res(sh_res), .sh_ctl(sh_ctl),
        .res(nx_res), .wr(nx_wr), .nzvc(nx_nzvc), .upd(nx_upd)
    );

    // Output register: capture on strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            wr_en     <= 1'b0;
            {n_out, z_out, v_out, c_out} <= 4'b0;
            {n_upd, z_upd, v_upd, c_upd} <= 4'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nx_res;
                wr_en  <= nx_wr;
                {n_out, z_out, v_out, c_out} <= nx_nzvc;
                {n_upd, z_upd, v_upd, c_upd} <= nx_upd;
            end
        end
    end
endmodule

// File: rtl/sop_alu_unit_chk.sv
// Checker: cycle-level properties of sop_alu_unit, bound to every instance.
module sop_alu_unit_chk #(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [3:0]   op_sel,
    input logic         byte_mode,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         wr_en,
    input logic         n_out,
    input logic         z_out,
    input logic         v_out,
    input logic         c_out,
    input logic         n_upd,
    input logic         z_upd,
    input logic         v_upd,
    input logic         c_upd
);
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_byte_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && byte_mode) |=> (result[W-1:BW] == '0));
    p_clear_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd0) |=> (result == '0 && z_out && !n_out && !v_out && !c_out));
    p_incdec_keep_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == 4'd2 || op_sel == 4'd3)) |=> !c_upd);
    p_shift_v_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel >= 4'd8 && op_sel <= 4'd11) |=> (v_out == (n_out ^ c_out)));
    p_test_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd7) |=> !wr_en);
    p_zero_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && z_upd) |-> (z_out == (result == '0)));
    p_unexec_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel >= 4'd12 && op_sel <= 4'd14)
        |=> (!wr_en && !n_upd && !z_upd && !v_upd && !c_upd));
endmodule

bind sop_alu_unit sop_alu_unit_chk #(.W(W), .BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .byte_mode(byte_mode), .out_valid(out_valid), .result(result),
    .wr_en(wr_en), .n_out(n_out), .z_out(z_out), .v_out(v_out),
    .c_out(c_out), .n_upd(n_upd), .z_upd(z_upd), .v_upd(v_upd),
    .c_upd(c_upd)
);

// File: tb/sop_alu_unit_test.sv
// Bench: directed corners plus seeded random operations, checked against
// a reference model written from the requirements.
module sop_alu_unit_test;

    typedef struct packed {
        logic [15:0] res;
        logic        wr;
        logic [3:0]  f;   // N Z V C
        logic [3:0]  u;   // masks N Z V C
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] operand = '0;
    logic        n_in = 1'b0, c_in = 1'b0;
    logic        out_valid, wr_en;
    logic [15:0] result;
    logic        n_out, z_out, v_out, c_out, n_upd, z_upd, v_upd, c_upd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sop_alu_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .byte_mode(byte_mode), .operand(operand), .n_in(n_in), .c_in(c_in),
        .out_valid(out_valid), .result(result), .wr_en(wr_en),
        .n_out(n_out), .z_out(z_out), .v_out(v_out), .c_out(c_out),
        .n_upd(n_upd), .z_upd(z_upd), .v_upd(v_upd), .c_upd(c_upd)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:  return "R3";
            4'd2, 4'd3:  return "R4";
            4'd4:        return "R5";
            4'd5, 4'd6:  return "R6";
            4'd7:        return "R10";
            4'd8, 4'd9:  return "R7";
            4'd10, 4'd11: return "R8";
            4'd15:       return "R11";
            default:     return "R13";
        endcase
    endfunction

    function automatic exp_t model(input logic [3:0] op, input logic bm,
                                   input logic [15:0] x, input logic n, input logic c);
        exp_t e;
        logic [15:0] m, s, v, r;
        logic vv, cc, so;
        m  = bm ? 16'h00FF : 16'hFFFF;
        s  = bm ? 16'h0080 : 16'h8000;
        v  = x & m;
        r  = 16'h0; vv = 1'b0; cc = 1'b0;
        e  = '0;
        e.wr = 1'b1;
        e.u  = 4'b1111;
        case (op)
            4'd0: r = 16'h0;
            4'd1: begin r = ~v; cc = 1'b1; end
            4'd2: begin r = (v + 16'd1) & m; vv = (r == s); e.u[0] = 1'b0; end
            4'd3: begin r = (v - 16'd1) & m; vv = (v == s); e.u[0] = 1'b0; end
            4'd4: begin r = (16'd0 - v) & m; vv = (r == s); cc = (r != 0); end
            4'd5: if (c) begin
                      r = (v + 16'd1) & m; cc = (r == 0);
                      vv = ((r & s) != 0) && ((v & s) == 0);
                  end else r = v;
            4'd6: if (c) begin
                      r = (v - 16'd1) & m; cc = (r == m);
                      vv = ((v & s) != 0) && ((r & s) == 0);
                  end else r = v;
            4'd7: begin r = v; e.wr = 1'b0; end
            4'd8: begin so = v[0]; r = (v >> 1) | (c ? s : 16'h0); cc = so; end
            4'd9: begin so = (v & s) != 0; r = (v << 1) | {15'h0, c}; cc = so; end
            4'd10: begin so = v[0]; r = (v >> 1) | (v & s); cc = so; end
            4'd11: begin so = (v & s) != 0; r = v << 1; cc = so; end
            4'd15: r = n ? m : 16'h0;
            default: begin e.wr = 1'b0; e.u = 4'b0000; end
        endcase
        r = r & m;
        if (op >= 4'd8 && op <= 4'd11) vv = ((r & s) != 0) ^ cc;
        if (op == 4'd15) e.u = 4'b0100;
        e.res  = (e.u == 4'b0000) ? 16'h0 : r;
        e.f[3] = e.u[3] ? ((r & s) != 0) : n;
        e.f[2] = e.u[2] ? ((op == 4'd15) ? ~n : (r == 0)) : 1'b0;
        e.f[1] = e.u[1] ? vv : 1'b0;
        e.f[0] = e.u[0] ? cc : c;
        return e;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic bm,
                          input logic [15:0] x, input logic n, input logic c);
        exp_t e;
        exp_t a;
        e = model(op, bm, x, n, c);
        @(negedge clk);
        op_sel = op; byte_mode = bm; operand = x; n_in = n; c_in = c;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        a = '{res: result, wr: wr_en, f: {n_out, z_out, v_out, c_out},
              u: {n_upd, z_upd, v_upd, c_upd}};
        check("R1", "out_valid", {31'd0, out_valid}, 32'd1);
        check(req_of(op), $sformatf("op %0d bm %0d x %h n %0d c %0d", op, bm, x, n, c),
              {5'd0, a}, {5'd0, e});
        if (bm) check("R2", "upper byte", {16'd0, result & 16'hFF00}, 32'd0);
        if (op >= 4'd8 && op <= 4'd11)
            check("R9", "V vs N^C", {31'd0, v_out}, {31'd0, n_out ^ c_out});
        if (z_upd) check("R12", "Z vs zero result", {31'd0, z_out}, {31'd0, result == 16'h0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R14: reset state
        check("R14", "outputs under reset",
              {12'd0, out_valid, wr_en, result, n_out, z_out, v_out, c_out},
              32'd0);
        check("R14", "masks under reset", {28'd0, n_upd, z_upd, v_upd, c_upd}, 32'd0);
        rst_n = 1'b1;

        // Directed corners, both sizes
        for (int bm = 0; bm < 2; bm++) begin
            run_op(4'd0, bm[0], 16'h1234, 1'b1, 1'b1);           // R3
            run_op(4'd1, bm[0], 16'hFFFF, 1'b0, 1'b0);           // R3
            run_op(4'd2, bm[0], bm ? 16'h007F : 16'h7FFF, 1'b0, 1'b1); // R4
            run_op(4'd2, bm[0], 16'hFFFF, 1'b0, 1'b0);           // R4 wrap
            run_op(4'd3, bm[0], bm ? 16'h0080 : 16'h8000, 1'b1, 1'b1); // R4
            run_op(4'd4, bm[0], bm ? 16'h0080 : 16'h8000, 1'b0, 1'b0); // R5
            run_op(4'd4, bm[0], 16'h0000, 1'b0, 1'b1);           // R5
            run_op(4'd5, bm[0], 16'hFFFF, 1'b0, 1'b1);           // R6 wrap
            run_op(4'd5, bm[0], bm ? 16'h007F : 16'h7FFF, 1'b0, 1'b1); // R6 V
            run_op(4'd5, bm[0], 16'h00F0, 1'b0, 1'b0);           // R6 c clear
            run_op(4'd6, bm[0], 16'h0000, 1'b0, 1'b1);           // R6 all ones
            run_op(4'd6, bm[0], bm ? 16'h0080 : 16'h8000, 1'b1, 1'b1); // R6 V
            run_op(4'd6, bm[0], 16'h0005, 1'b0, 1'b0);           // R6 c clear
            run_op(4'd7, bm[0], 16'hAB00, 1'b1, 1'b1);           // R10
            run_op(4'd8, bm[0], 16'h0001, 1'b0, 1'b1);           // R7
            run_op(4'd9, bm[0], bm ? 16'h0080 : 16'h8000, 1'b0, 1'b1); // R7
            run_op(4'd10, bm[0], bm ? 16'h0081 : 16'h8001, 1'b0, 1'b0); // R8
            run_op(4'd11, bm[0], bm ? 16'h00C0 : 16'hC000, 1'b0, 1'b0); // R8
            run_op(4'd15, bm[0], 16'h1234, 1'b1, 1'b0);          // R11
            run_op(4'd15, bm[0], 16'h1234, 1'b0, 1'b1);          // R11
            run_op(4'd12, bm[0], 16'h5555, 1'b1, 1'b1);          // R13
            run_op(4'd14, bm[0], 16'h0000, 1'b0, 1'b0);          // R13
        end

        // R1: no strobe, no valid
        @(negedge clk);
        check("R1", "out_valid idle", {31'd0, out_valid}, 32'd0);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            run_op(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                   16'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule